// File: doc/BRIEF.md
# GPIO Register File with Pin Interrupts

This block is the memory-mapped control and status front end of an eight-pin general-purpose I/O port. It sits on an APB slave port. It holds the output-data and output-enable registers that drive the pin core, and it returns the synchronized pin levels on a read. The pin core does the synchronization and edge detection. This block does not.

The pin core also delivers four condition flags per pin: level high, level low, rising edge and falling edge. The block captures each flag into a sticky raw-status bit. Software selects the sources that may interrupt through an enable register. It reads the raw and enabled (masked) status, and it acknowledges sources by writing ones to a clear register. A single interrupt request line is raised while any enabled source is pending.

Every transfer completes in its access phase with no wait state and no error response.

Top module: `gpio_apb_regs`

## Requirements
- R1: After reset, every readable register returns 0x00000000, `pin_out`, `pin_oe` and `irq` are 0.
- R2: A read of offset 0x0000 returns `pin_state` in bits NPINS-1:0 with zeros above it. A write to 0x0000 changes nothing.
- R3: A write at 0x0004 loads the output-data register and a write at 0x0008 loads the output-enable register (1 = drive). Both registers take their low NPINS bits of `pwdata` at the clock edge that ends the access phase, drive `pin_out`/`pin_oe`, and read back at the same offsets.
- R4: Source bit k*NPINS+p belongs to pin p, with kind k = 0 level high, 1 level low, 2 rising edge, 3 falling edge. Flag `cond_flags[i]` sets status bit i.
- R5: A raw-status bit (read at 0xFF08) is set at the first clock edge where its flag is 1, whatever the enable register holds, and stays set after the flag drops until it is cleared.
- R6: Writing to 0xFF0C clears each raw bit whose `pwdata` bit is 1 and leaves the bits written 0 unchanged. Offset 0xFF0C reads as zero.
- R7: When a flag is 1 in the same cycle as a clear of its bit, the bit stays set.
- R8: Offset 0xFF00 is the read/write enable register. A read of 0xFF04 returns raw status AND enable. Writes to 0xFF04 and 0xFF08 have no effect.
- R9: `irq` is 1 exactly when some bit of raw status AND enable is 1.
- R10: Reads of unmapped offsets return zero and writes to them change nothing. `pready` is always 1 and `pslverr` is always 0.
- R11: Registers change only in the access phase (`psel` and `penable` both 1). A setup phase alone writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | 16 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when not selected |
| pready | output | 1 | Transfer complete, tied high |
| pslverr | output | 1 | Error response, tied low |
| pin_state | input | NPINS | Synchronized pin levels from the pin core |
| cond_flags | input | 4*NPINS | Per-pin condition flags in the R4 layout |
| pin_out | output | NPINS | Output data to the pins |
| pin_oe | output | NPINS | Output enable to the pins |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default NPINS of 8, which gives 32 sources. Every bit of the status, enable and clear words is then a live source, so the upper edge-flag bytes and the bit-31 boundary are exercised along with the level bytes. This width also makes the zero-extension of the 8-bit data registers visible in the upper 24 bits of each read. A reference model in the bench tracks the enable and raw status through flag pulses, held flags and clear writes, so both the sticky hold and the set-wins collision can be observed on reads and on `irq`.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_PIN_IN     = 16'h0000;
  localparam logic [ADDR_W-1:0] OFS_PIN_OUT    = 16'h0004;
  localparam logic [ADDR_W-1:0] OFS_PIN_OE     = 16'h0008;
  localparam logic [ADDR_W-1:0] OFS_IRQ_EN     = 16'hFF00;
  localparam logic [ADDR_W-1:0] OFS_IRQ_MASKED = 16'hFF04;
  localparam logic [ADDR_W-1:0] OFS_IRQ_RAW    = 16'hFF08;
  localparam logic [ADDR_W-1:0] OFS_IRQ_CLR    = 16'hFF0C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PIN_IN, SEL_PIN_OUT, SEL_PIN_OE,
    SEL_IRQ_EN, SEL_IRQ_MASKED, SEL_IRQ_RAW, SEL_IRQ_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_PIN_IN:     return SEL_PIN_IN;
      OFS_PIN_OUT:    return SEL_PIN_OUT;
      OFS_PIN_OE:     return SEL_PIN_OE;
      OFS_IRQ_EN:     return SEL_IRQ_EN;
      OFS_IRQ_MASKED: return SEL_IRQ_MASKED;
      OFS_IRQ_RAW:    return SEL_IRQ_RAW;
      OFS_IRQ_CLR:    return SEL_IRQ_CLR;
      default:        return SEL_NONE;
    endcase
  endfunction

  // One status bit: a set in the same cycle as a clear keeps the bit.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/gpio_apb_decode.sv
module gpio_apb_decode
  import gpio_regs_pkg::*;
(
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output reg_sel_e          sel,
  output logic              wr_out,
  output logic              wr_oe,
  output logic              wr_en,
  output logic              wr_clr
);
  logic access_wr;

  assign sel       = decode_offset(paddr);
  assign access_wr = psel & penable & pwrite;
  assign wr_out    = access_wr & (sel == SEL_PIN_OUT);
  assign wr_oe     = access_wr & (sel == SEL_PIN_OE);
  assign wr_en     = access_wr & (sel == SEL_IRQ_EN);
  assign wr_clr    = access_wr & (sel == SEL_IRQ_CLR);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_out,
  input  logic             wr_oe,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] oe_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      if (wr_out) out_q <= wdata;
      if (wr_oe)  oe_q  <= wdata;
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_clr,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] set_flags,
  output logic [NSRC-1:0] enable_q,
  output logic [NSRC-1:0] raw_q,
  output logic [NSRC-1:0] masked,
  output logic            irq
);
  logic [NSRC-1:0] clr_vec;

  assign clr_vec = wr_clr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable_q <= '0;
    else if (wr_en) enable_q <= wdata;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q[i] <= 1'b0;
      else        raw_q[i] <= sticky_next(raw_q[i], set_flags[i], clr_vec[i]);
    end
  end

  assign masked = raw_q & enable_q;
  assign irq    = |masked;
endmodule

// File: rtl/gpio_apb_regs.sv
module gpio_apb_regs
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [DATA_W-1:0]    pwdata,
  output logic [DATA_W-1:0]    prdata,
  output logic                 pready,
  output logic                 pslverr,
  input  logic [NPINS-1:0]     pin_state,
  input  logic [4*NPINS-1:0]   cond_flags,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe,
  output logic                 irq
);
  localparam int unsigned NSRC = 4 * NPINS;

  reg_sel_e        sel;
  logic            wr_out_s, wr_oe_s, wr_en_s, wr_clr_s;
  logic [NSRC-1:0] enable_q, raw_q, masked;

  gpio_apb_decode u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .sel(sel), .wr_out(wr_out_s), .wr_oe(wr_oe_s), .wr_en(wr_en_s), .wr_clr(wr_clr_s)
  );

  gpio_port_regs #(.NPINS(NPINS)) u_port (
    .clk(clk), .rst_n(rst_n), .wr_out(wr_out_s), .wr_oe(wr_oe_s),
    .wdata(pwdata[NPINS-1:0]), .out_q(pin_out), .oe_q(pin_oe)
  );

  gpio_irq_unit #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_s), .wr_clr(wr_clr_s),
    .wdata(pwdata[NSRC-1:0]), .set_flags(cond_flags),
    .enable_q(enable_q), .raw_q(raw_q), .masked(masked), .irq(irq)
  );

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (sel)
        SEL_PIN_IN:     prdata = DATA_W'(pin_state);
        SEL_PIN_OUT:    prdata = DATA_W'(pin_out);
        SEL_PIN_OE:     prdata = DATA_W'(pin_oe);
        SEL_IRQ_EN:     prdata = DATA_W'(enable_q);
        SEL_IRQ_MASKED: prdata = DATA_W'(masked);
        SEL_IRQ_RAW:    prdata = DATA_W'(raw_q);
        default:        prdata = '0;
      endcase
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/gpio_apb_regs_checker.sv
module gpio_apb_regs_checker
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               psel,
  input logic               penable,
  input logic [ADDR_W-1:0]  paddr,
  input logic [DATA_W-1:0]  pwdata,
  input logic [DATA_W-1:0]  prdata,
  input logic               wr_out,
  input logic               wr_clr,
  input logic [4*NPINS-1:0] set_flags,
  input logic [4*NPINS-1:0] raw,
  input logic [4*NPINS-1:0] enable,
  input logic [NPINS-1:0]   pin_out,
  input logic [NPINS-1:0]   pin_oe,
  input logic               irq
);
  localparam int unsigned NSRC = 4 * NPINS;

  a_r3_out_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> pin_out == $past(pwdata[NPINS-1:0]));

  a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> ((raw & $past(raw)) == $past(raw)));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_flags) |=> ((raw & $past(set_flags)) == $past(set_flags)));

  a_r6_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && set_flags == '0) |=> ((raw & $past(pwdata[NSRC-1:0])) == '0));

  a_r8_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && paddr == OFS_IRQ_MASKED) |-> prdata == DATA_W'(raw & enable));

  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(raw & enable)));

  a_r11_setup_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(enable)));
endmodule

bind gpio_apb_regs gpio_apb_regs_checker #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .paddr(paddr),
  .pwdata(pwdata), .prdata(prdata), .wr_out(wr_out_s), .wr_clr(wr_clr_s),
  .set_flags(cond_flags), .raw(raw_q), .enable(enable_q),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/test_gpio_apb_regs.sv
module test_gpio_apb_regs;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [NP-1:0]   pin_state = '0;
  logic [4*NP-1:0] cond_flags = '0;
  logic [NP-1:0]   pin_out, pin_oe;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0]  m_out = '0, m_oe = '0;
  logic [31:0] m_en = '0, m_raw = '0;

  always #4 clk = ~clk;

  gpio_apb_regs #(.NPINS(NP)) i_gpio_apb_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pin_state(pin_state), .cond_flags(cond_flags),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  typedef struct packed { logic [1:0] op; logic [15:0] addr; logic [31:0] data; } vec_t;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_FLAG = 2'd2;
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 16'h0004, 32'hFFFF_FFA5}, '{OP_RD, 16'h0004, 32'h0},
    '{OP_WR, 16'h0008, 32'h0000_000F}, '{OP_RD, 16'h0008, 32'h0},
    '{OP_WR, 16'hFF00, 32'h8000_0100}, '{OP_RD, 16'hFF00, 32'h0},
    '{OP_FLAG, 16'h0, 32'h8001_0203},  '{OP_RD, 16'hFF08, 32'h0},
    '{OP_RD, 16'hFF04, 32'h0},         '{OP_WR, 16'hFF0C, 32'h0000_0203},
    '{OP_RD, 16'hFF08, 32'h0},         '{OP_RD, 16'hFF04, 32'h0},
    '{OP_WR, 16'h0010, 32'hFFFF_FFFF}, '{OP_RD, 16'h0010, 32'h0},
    '{OP_WR, 16'hFF08, 32'hFFFF_FFFF}, '{OP_WR, 16'hFF04, 32'hFFFF_FFFF},
    '{OP_RD, 16'hFF08, 32'h0},         '{OP_WR, 16'hFF0C, 32'h8001_0000},
    '{OP_RD, 16'hFF0C, 32'h0},         '{OP_RD, 16'hFF08, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [15:0] a);
    case (a)
      16'h0000: return {24'h0, pin_state};
      16'h0004: return {24'h0, m_out};
      16'h0008: return {24'h0, m_oe};
      16'hFF00: return m_en;
      16'hFF04: return m_raw & m_en;
      16'hFF08: return m_raw;
      default:  return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [31:0] d, input logic [31:0] held);
    case (a)
      16'h0004: m_out = d[7:0];
      16'h0008: m_oe  = d[7:0];
      16'hFF00: m_en  = d;
      16'hFF0C: m_raw = (m_raw & ~d) | held;
      default: ;
    endcase
  endtask

  task automatic apb_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    model_write(a, d, cond_flags);
  endtask

  task automatic apb_rd(input string req, input logic [15:0] a);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 check(req, prdata, model_read(a));
    check(req, {31'h0, pready & ~pslverr}, 32'h1);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic flag_pulse(input logic [31:0] f);
    @(negedge clk); cond_flags = f;
    @(negedge clk); cond_flags = '0;
    m_raw = m_raw | f;
  endtask

  task automatic check_pins_irq(input string req);
    check({req, " pins"}, {16'h0, pin_oe, pin_out}, {16'h0, m_oe, m_out});
    check({req, " R9 irq"}, {31'h0, irq}, {31'h0, |(m_raw & m_en)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_pins_irq("R1");
    apb_rd("R1 out", 16'h0004); apb_rd("R1 oe", 16'h0008);
    apb_rd("R1 en", 16'hFF00); apb_rd("R1 raw", 16'hFF08); apb_rd("R1 masked", 16'hFF04);

    // table: R3 R8 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   apb_wr(VECS[i].addr, VECS[i].data);
        OP_RD:   apb_rd("R3/R5/R6/R8/R10 vector read", VECS[i].addr);
        default: flag_pulse(VECS[i].data);
      endcase
      check_pins_irq("R3/R9 vector");
    end

    // R2 data-in read and ignored write
    pin_state = 8'h5A;
    apb_rd("R2 pin read", 16'h0000);
    apb_wr(16'h0000, 32'hFFFF_FFFF);
    pin_state = 8'hC3;
    apb_rd("R2 pin read after write", 16'h0000);
    check_pins_irq("R2");

    // R11 setup phase alone
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 16'h0004; pwdata = 32'h3C;
    @(negedge clk); psel = 0; pwrite = 0;
    apb_rd("R11 setup only", 16'h0004);
    check_pins_irq("R11");

    // R4 layout: one flag per kind on distinct pins
    apb_wr(16'hFF0C, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      flag_pulse(32'h1 << (k * NP + k + 2));
      apb_rd("R4 layout", 16'hFF08);
    end

    // R5 set regardless of enable, held after flag drops
    apb_wr(16'hFF00, 32'h0);
    flag_pulse(32'h0000_8000);
    repeat (4) @(negedge clk);
    apb_rd("R5 sticky", 16'hFF08);
    check_pins_irq("R5");

    // R7 set wins: flag bit 5 held during clear of bits 5 and 15
    @(negedge clk); cond_flags = 32'h0000_0020;
    apb_wr(16'hFF0C, 32'h0000_8020);
    @(negedge clk); cond_flags = '0;
    apb_rd("R7 set wins", 16'hFF08);

    // R9 irq rises on enabling a pending source
    apb_wr(16'hFF00, 32'h0000_0020);
    check_pins_irq("R9 enable");
    apb_wr(16'hFF0C, 32'h0000_0020);
    check_pins_irq("R9 clear");

    // R6 clear writes 0 leave bits; clear reads zero
    flag_pulse(32'h0300_0000);
    apb_wr(16'hFF0C, 32'h0100_0000);
    apb_rd("R6 partial clear", 16'hFF08);
    apb_rd("R6 clear reads zero", 16'hFF0C);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule